// File: doc/BRIEF.md
# Sinc3 Decimator with Symmetric FIR Equalizer

This block converts a one-bit oversampled modulator stream into signed 24-bit output words. Each accepted bit is mapped to +1 or -1. The mapped bit feeds a chain of three wrapping integrators that run at the master-clock rate. A counter of accepted bits picks every N-th integrator value. N is the decimation ratio on the `ratio` input. At the nominal operating point, N is the master clock divided by the output rate, for example 24.576 MHz / 16 kHz = 1536. Three comb differentiators then run at the decimated rate and complete the third-order sinc response.

Each decimated value enters a 9-tap symmetric FIR filter that shapes the final passband. The FIR uses a small state machine with three states:

- `FIR_IDLE` waits for a decimated value.
- `FIR_MAC` folds one mirrored pair of history samples per cycle into a single shared multiplier, which takes five cycles.
- `FIR_SCALE` rounds and saturates the sum to 24 bits.

The transitions are:

- idle-to-mac, when a decimated value arrives;
- mac-to-scale, after the centre tap;
- scale-to-idle, unconditionally.

The output is a one-cycle valid pulse with a held data word. The filter response scales with the chosen output rate; at 16 ksps the -3 dB point lies near 3.4 kHz. The two filter stages together add about six output periods of delay. `ratio` may change only while `rst_n` is low.

Top module: `sinc3_fir_decim`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `sample_vld` is 0 and `sample_out` is 0. The integrators, combs and FIR history all clear to zero.
- R2: Exactly one decimated sample is produced per effective-ratio accepted bits. A bit is accepted when `bit_vld` is 1. Cycles with `bit_vld` low change nothing.
- R3: A `ratio` value below 8 acts as a ratio of 8.
- R4: Bit value 1 counts as +1 and 0 as -1. The sinc3 value is the third difference of the sequence of triple running sums, taken at each decimation point. Those sums are held modulo 2^(3*RATIO_W+1).
- R5: The FIR output before scaling is the sum of c[k]*x[n-k], where x[n] is the newest sinc3 value and c = 11, -37, -18, 156, 276, 156, -18, -37, 11. The history starts at zero.
- R6: The FIR sum is divided by 2^(9+OUT_SHIFT) with rounding: half is added, then the result is floored.
- R7: The rounded result saturates to the range -8388608 to 8388607.
- R8: `sample_vld` is high for single cycles only, and `sample_out` stays unchanged in every cycle where `sample_vld` is low.
- R9: A new decimated value reaches the FIR only while it is in `FIR_IDLE`, so no value is ever lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Modulator bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| ratio | input | RATIO_W | Decimation ratio, held constant outside reset |
| sample_out | output | 24 | Signed filtered sample |
| sample_vld | output | 1 | One-cycle strobe for `sample_out` |

## Verification
The assertions check four properties on every cycle:

- each decimation window contains exactly the effective ratio of accepted bits;
- the FIR is idle whenever a comb value arrives;
- valid pulses are single cycles that follow FIR activity;
- the output word holds between pulses.

The numerical behaviour can only be shown by the bench's scenarios, which compare every word against a bench model. This covers the sign mapping, the sinc3 differencing, the tap weights, rounding and saturation at both rails, the ratio floor, and stalls on `bit_vld`.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int CIC_ORDER = 3;
    localparam int TAPS      = 9;
    localparam int PAIRS     = (TAPS + 1) / 2;
    localparam int COEF_W    = 10;
    localparam int COEF_FRAC = 9;
    localparam int MIN_RATIO = 8;

    typedef enum logic [1:0] {
        FIR_IDLE,
        FIR_MAC,
        FIR_SCALE
    } fir_state_t;

    // weights in units of 1/512, outer pair first, centre last
    function automatic logic signed [COEF_W-1:0] tap_coef(input int k);
        case (k)
            0:       tap_coef = 10'sd11;
            1:       tap_coef = -10'sd37;
            2:       tap_coef = -10'sd18;
            3:       tap_coef = 10'sd156;
            default: tap_coef = 10'sd276;
        endcase
    endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sdf_pkg::*;
#(
    parameter int RATIO_W = 11,
    parameter int ACC_W   = CIC_ORDER * RATIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_vld,
    input  logic [RATIO_W-1:0] ratio,
    output logic [ACC_W-1:0]   dec_data,
    output logic               dec_vld
);
    logic [RATIO_W-1:0] eff_ratio;
    logic [RATIO_W-1:0] bit_cnt;
    logic [ACC_W-1:0]   step;
    logic [ACC_W-1:0]   sum_q [CIC_ORDER];
    logic [ACC_W-1:0]   sum_d [CIC_ORDER];

    assign eff_ratio = (ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : ratio;
    assign step      = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    for (genvar g = 0; g < CIC_ORDER; g++) begin : g_integ
        if (g == 0) begin : g_first
            assign sum_d[g] = sum_q[g] + step;
        end else begin : g_rest
            assign sum_d[g] = sum_q[g] + sum_d[g-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q[g] <= '0;
            end else if (bit_vld) begin
                sum_q[g] <= sum_d[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            dec_data <= '0;
            dec_vld  <= 1'b0;
        end else begin
            dec_vld <= 1'b0;
            if (bit_vld) begin
                if (bit_cnt == eff_ratio - 1'b1) begin
                    bit_cnt  <= '0;
                    dec_data <= sum_d[CIC_ORDER-1];
                    dec_vld  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sdf_pkg::*;
#(
    parameter int ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] in_data,
    input  logic             in_vld,
    output logic [ACC_W-1:0] out_data,
    output logic             out_vld
);
    logic [ACC_W-1:0] dly_q [CIC_ORDER];
    logic [ACC_W-1:0] diff  [CIC_ORDER+1];

    assign diff[0] = in_data;

    for (genvar g = 0; g < CIC_ORDER; g++) begin : g_comb
        assign diff[g+1] = diff[g] - dly_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q[g] <= '0;
            end else if (in_vld) begin
                dly_q[g] <= diff[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_data <= diff[CIC_ORDER];
            end
        end
    end
endmodule

// File: rtl/fir9_sym.sv
module fir9_sym
    import sdf_pkg::*;
#(
    parameter int IN_W      = 34,
    parameter int OUT_W     = 24,
    parameter int OUT_SHIFT = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_vld,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_vld,
    output logic                    busy
);
    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(PAIRS) + 1;
    localparam int SH     = COEF_FRAC + OUT_SHIFT;
    localparam int IDX_W  = $clog2(PAIRS);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(64'sd1 <<< (OUT_W-1));

    fir_state_t state, state_nx;

    logic signed [IN_W-1:0]   hist [TAPS];
    logic        [IDX_W-1:0]  idx;
    logic signed [ACC_W-1:0]  acc;
    logic signed [PRE_W-1:0]  pre;
    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  rnd;
    logic signed [ACC_W-1:0]  scaled;
    logic signed [OUT_W-1:0]  sat;

    // mirrored pair pre-add; centre tap stands alone
    always_comb begin
        if (int'(idx) == PAIRS - 1) begin
            pre = PRE_W'(hist[idx]);
        end else begin
            pre = PRE_W'(hist[idx]) + PRE_W'(hist[TAPS-1-int'(idx)]);
        end
        coef = tap_coef(int'(idx));
        prod = pre * coef;
    end

    always_comb begin
        rnd    = acc + (ACC_W'(1) <<< (SH - 1));
        scaled = rnd >>> SH;
        if (scaled > SAT_HI) begin
            sat = OUT_W'(SAT_HI);
        end else if (scaled < SAT_LO) begin
            sat = OUT_W'(SAT_LO);
        end else begin
            sat = OUT_W'(scaled);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FIR_IDLE:  if (in_vld) state_nx = FIR_MAC;
            FIR_MAC:   if (int'(idx) == PAIRS - 1) state_nx = FIR_SCALE;
            FIR_SCALE: state_nx = FIR_IDLE;
            default:   state_nx = FIR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FIR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) hist[k] <= '0;
            idx <= '0;
            acc <= '0;
        end else begin
            if (state == FIR_IDLE && in_vld) begin
                hist[0] <= in_data;
                for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
                idx <= '0;
                acc <= '0;
            end else if (state == FIR_MAC) begin
                acc <= acc + ACC_W'(prod);
                idx <= idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= (state == FIR_SCALE);
            if (state == FIR_SCALE) begin
                out_data <= sat;
            end
        end
    end

    assign busy = (state != FIR_IDLE);
endmodule

// File: rtl/sinc3_fir_decim.sv
module sinc3_fir_decim
    import sdf_pkg::*;
#(
    parameter int RATIO_W   = 11,
    parameter int OUT_W     = 24,
    parameter int OUT_SHIFT = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_in,
    input  logic                    bit_vld,
    input  logic [RATIO_W-1:0]      ratio,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sample_vld
);
    localparam int ACC_W = CIC_ORDER * RATIO_W + 1;

    logic [ACC_W-1:0] dec_data;
    logic             dec_vld;
    logic [ACC_W-1:0] cic_data;
    logic             cic_vld;
    logic             fir_busy;

    sinc3_integ #(.RATIO_W(RATIO_W), .ACC_W(ACC_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .ratio    (ratio),
        .dec_data (dec_data),
        .dec_vld  (dec_vld)
    );

    sinc3_comb #(.ACC_W(ACC_W)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (dec_data),
        .in_vld   (dec_vld),
        .out_data (cic_data),
        .out_vld  (cic_vld)
    );

    fir9_sym #(.IN_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_fir (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (cic_data),
        .in_vld   (cic_vld),
        .out_data (sample_out),
        .out_vld  (sample_vld),
        .busy     (fir_busy)
    );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker
    import sdf_pkg::*;
#(
    parameter int RATIO_W = 11,
    parameter int OUT_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_vld,
    input logic [RATIO_W-1:0] ratio,
    input logic               dec_vld,
    input logic               cic_vld,
    input logic               fir_busy,
    input logic               sample_vld,
    input logic [OUT_W-1:0]   sample_out
);
    logic [RATIO_W-1:0] eff;
    logic [RATIO_W:0]   win_cnt;

    assign eff = (ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : ratio;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (dec_vld) begin
            win_cnt <= bit_vld ? (RATIO_W+1)'(1) : '0;
        end else if (bit_vld) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // R2 R3
    dec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> (win_cnt == {1'b0, eff}));

    // R9
    fir_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cic_vld |-> !fir_busy);

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample_out));

    // R9
    vld_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(fir_busy));
endmodule

bind sinc3_fir_decim sdf_checker #(.RATIO_W(RATIO_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .ratio      (ratio),
    .dec_vld    (dec_vld),
    .cic_vld    (cic_vld),
    .fir_busy   (fir_busy),
    .sample_vld (sample_vld),
    .sample_out (sample_out)
);

// File: tb/test_sinc3_fir_decim.sv
module test_sinc3_fir_decim;
    localparam int RATIO_W   = 11;
    localparam int OUT_W     = 24;
    localparam int OUT_SHIFT = 0;
    localparam int SH        = 9 + OUT_SHIFT;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               bit_in;
    logic               bit_vld;
    logic [RATIO_W-1:0] ratio;
    logic signed [OUT_W-1:0] sample_out;
    logic               sample_vld;

    always #10 clk = ~clk;

    sinc3_fir_decim #(.RATIO_W(RATIO_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) i_sinc3_fir_decim (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .ratio      (ratio),
        .sample_out (sample_out),
        .sample_vld (sample_vld)
    );

    int     n_chk  = 0;
    int     n_fail = 0;
    int     n_out  = 0;
    int     cyc    = 0;
    string  cur_req = "R5";
    longint exp_q[$];
    longint s1, s2, s3, z1, z2, z3;
    longint hist [9];
    int     cnt, eff;

    function automatic longint coef(input int k);
        case (k)
            0, 8: return 11;
            1, 7: return -37;
            2, 6: return -18;
            3, 5: return 156;
            default: return 276;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset(input int r);
        s1 = 0; s2 = 0; s3 = 0; z1 = 0; z2 = 0; z3 = 0; cnt = 0;
        for (int k = 0; k < 9; k++) hist[k] = 0;
        eff = (r < 8) ? 8 : r;
        exp_q.delete();
        n_out = 0;
    endtask

    task automatic model_bit(input bit b);
        longint c1, c2, c3, acc, rv;
        s1 += b ? 1 : -1;
        s2 += s1;
        s3 += s2;
        cnt++;
        if (cnt == eff) begin
            cnt = 0;
            c1 = s3 - z1; z1 = s3;
            c2 = c1 - z2; z2 = c1;
            c3 = c2 - z3; z3 = c2;
            for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = c3;
            acc = 0;
            for (int k = 0; k < 9; k++) acc += coef(k) * hist[k];
            rv = (acc + (64'sd1 <<< (SH - 1))) >>> SH;
            if (rv > 8388607) rv = 8388607;
            if (rv < -8388608) rv = -8388608;
            exp_q.push_back(rv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && sample_vld) begin
            n_out++;
            if (exp_q.size() == 0) begin
                check(cur_req, 1, 0);
            end else begin
                check(cur_req, longint'(sample_out), exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic start(input int r);
        @(negedge clk);
        rst_n   = 1'b0;
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        ratio   = RATIO_W'(r);
        model_reset(r);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 ones, 1 zeros, 2 random, 3 alternating
    task automatic drive(input int nbits, input int mode, input int gap_pct);
        int sent = 0;
        bit b;
        while (sent < nbits) begin
            @(negedge clk);
            if (int'($urandom % 100) < gap_pct) begin
                bit_vld = 1'b0;
                bit_in  = $urandom % 2;
            end else begin
                case (mode)
                    0: b = 1'b1;
                    1: b = 1'b0;
                    2: b = $urandom % 2;
                    default: b = sent[0];
                endcase
                bit_in  = b;
                bit_vld = 1'b1;
                model_bit(b);
                sent++;
            end
        end
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_scn(input string req, input int nbits);
        check(req, n_out, nbits / eff);
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; ratio = 16;
        model_reset(16);
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", longint'(sample_vld), 0);
        check("R1", longint'(sample_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(sample_vld), 0);
        check("R1", longint'(sample_out), 0);

        // R4 R5: constant ones settle at 4000
        cur_req = "R4_R5";
        start(16); drive(400, 0, 0); finish_scn("R2", 400);

        // R2: random stalls on bit_vld, random bits
        cur_req = "R2_R4_R6";
        start(20); drive(2000, 2, 30); finish_scn("R2", 2000);

        // R3: ratio below the floor
        cur_req = "R3";
        start(3); drive(400, 2, 10); finish_scn("R3", 400);
        start(0); drive(240, 3, 0); finish_scn("R3", 240);

        // R6: alternating pattern exercises rounding near zero
        cur_req = "R6";
        start(17); drive(500, 3, 5); finish_scn("R6", 500);

        // R7: saturation at both rails
        cur_req = "R7";
        start(256); drive(3584, 0, 0); finish_scn("R7", 3584);
        start(256); drive(3584, 1, 0); finish_scn("R7", 3584);

        // R5: mixed random at a larger ratio
        cur_req = "R5_R6";
        start(99); drive(3000, 2, 20); finish_scn("R5", 3000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule